// File: doc/BRIEF.md
# Privileged Segment Address Decoder

This block is the combinational front end of an address translation path. It takes a virtual address, the current privilege mode and an error-level flag. It sorts the address into one of five fixed windows by looking only at the top three address bits, then checks the mode against that window's access rule. The result is one of three outcomes. The address may be translated directly by removing a fixed window base. It may be handed to a TLB lookup unit outside this block. Or it may be rejected with a bad-address fault.

When the request goes to the TLB, the lookup unit's physical address, permissions and result code are passed to the outputs unchanged. The TLB can therefore be a real lookup unit or a behavioural stub. When the error-level flag is set, the lowest window skips the TLB and maps each address onto itself.

Top module: `privseg_decoder`

## Requirements
- R1: With `erl_i` low, any address whose top bit is 0 is sent to the TLB in every mode: `tlb_req_o` is 1 and `pa_o`, `rd_ok_o`, `wr_ok_o`, `result_o` equal `tlb_pa_i`, `tlb_rd_i`, `tlb_wr_i`, `tlb_res_i`.
- R2: With `erl_i` high, any address whose top bit is 0 is unmapped in every mode: `tlb_req_o`=0, `pa_o`=`va_i`, `rd_ok_o`=`wr_ok_o`=1, `result_o`=0 (success).
- R3: Addresses 0x80000000 to 0x9FFFFFFF in kernel mode are unmapped with `pa_o`=`va_i`-0x80000000, both permissions set, `result_o`=0.
- R4: Addresses 0xA0000000 to 0xBFFFFFFF in kernel mode are unmapped with `pa_o`=`va_i`-0xA0000000, both permissions set, `result_o`=0.
- R5: Addresses 0xC0000000 to 0xDFFFFFFF go to the TLB (same pass-through as R1) in supervisor and kernel mode.
- R6: Addresses 0xE0000000 to 0xFFFFFFFF go to the TLB (same pass-through as R1) only in kernel mode.
- R7: Every privilege violation gives `result_o`=1 (bad address), `tlb_req_o`=0, `pa_o`=0, `rd_ok_o`=`wr_ok_o`=0. The violations are any of the upper four windows in user mode, and the two unmapped windows or the top window in supervisor mode.
- R8: `mode_i` encodes 00 kernel, 01 supervisor, 10 user, and 11 behaves exactly as 10.
- R9: Any 3-bit `tlb_res_i` value, including codes other than 0 and 1, reaches `result_o` unchanged when `tlb_req_o` is 1. When `tlb_req_o` is 0, the TLB inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| va_i | input | 32 | Virtual address |
| mode_i | input | 2 | Privilege mode (00 kernel, 01 supervisor, 1x user) |
| erl_i | input | 1 | Error-level flag; lowest window becomes identity-mapped |
| tlb_pa_i | input | 32 | Physical address from the TLB lookup |
| tlb_rd_i | input | 1 | Read permission from the TLB lookup |
| tlb_wr_i | input | 1 | Write permission from the TLB lookup |
| tlb_res_i | input | 3 | Result code from the TLB lookup |
| tlb_req_o | output | 1 | Request is TLB-mapped; TLB outputs are selected |
| pa_o | output | 32 | Physical address |
| rd_ok_o | output | 1 | Read permitted |
| wr_ok_o | output | 1 | Write permitted |
| result_o | output | 3 | Result code: 0 success, 1 bad address, others from the TLB |

## Verification
The error-level override and the privilege rule act together on the lowest window. The override must win in user mode as well as in kernel mode, while the other windows in the same cycle keep their normal privilege rules. The bench provokes this with random addresses, modes and flag values, plus directed cases of user mode with the flag set at both edges of the lowest window. It also drives the TLB inputs with values that differ from the expected direct result, so that a wrong selection between the two paths shows up in `pa_o` and `result_o`.

// File: rtl/privseg_pkg.sv
package privseg_pkg;
   typedef enum logic [2:0] {
      WIN_LOW  = 3'd0,
      WIN_DIR0 = 3'd1,
      WIN_DIR1 = 3'd2,
      WIN_SUP  = 3'd3,
      WIN_TOP  = 3'd4
   } win_t;

   typedef enum logic [1:0] {
      PRV_KERNEL = 2'd0,
      PRV_SUPER  = 2'd1,
      PRV_USER   = 2'd2
   } prv_t;

   typedef enum logic [1:0] {
      ROUTE_DIRECT = 2'd0,
      ROUTE_TLB    = 2'd1,
      ROUTE_FAULT  = 2'd2
   } route_t;

   localparam int unsigned RES_W      = 3;
   localparam logic [2:0]  RES_OK     = 3'd0;
   localparam logic [2:0]  RES_BADADR = 3'd1;
endpackage

// File: rtl/privseg_classify.sv
module privseg_classify
   import privseg_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] va_i,
   output win_t              win_o
);
   localparam int unsigned SEL_W = 3;
   localparam int unsigned SEL_LO = ADDR_W - SEL_W;

   logic [SEL_W-1:0] sel;
   assign sel = va_i[ADDR_W-1:SEL_LO];

   always_comb begin
      unique casez (sel)
         3'b0??:  win_o = WIN_LOW;
         3'b100:  win_o = WIN_DIR0;
         3'b101:  win_o = WIN_DIR1;
         3'b110:  win_o = WIN_SUP;
         default: win_o = WIN_TOP;
      endcase
   end
endmodule

// File: rtl/privseg_priv.sv
module privseg_priv
   import privseg_pkg::*;
#(
   parameter bit ERL_OVERRIDE_EN = 1'b1
) (
   input  win_t       win_i,
   input  logic [1:0] mode_i,
   input  logic       erl_i,
   output route_t     route_o
);
   prv_t prv;
   logic erl_eff;

   always_comb begin
      unique case (mode_i)
         2'b00:   prv = PRV_KERNEL;
         2'b01:   prv = PRV_SUPER;
         default: prv = PRV_USER;
      endcase
   end

   generate
      if (ERL_OVERRIDE_EN) begin : g_erl
         assign erl_eff = erl_i;
      end else begin : g_no_erl
         logic unused_erl;
         assign unused_erl = erl_i;
         assign erl_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      route_o = ROUTE_FAULT;
      unique case (win_i)
         WIN_LOW:  route_o = erl_eff ? ROUTE_DIRECT : ROUTE_TLB;
         WIN_DIR0,
         WIN_DIR1: if (prv == PRV_KERNEL) route_o = ROUTE_DIRECT;
         WIN_SUP:  if (prv != PRV_USER)   route_o = ROUTE_TLB;
         WIN_TOP:  if (prv == PRV_KERNEL) route_o = ROUTE_TLB;
         default:  route_o = ROUTE_FAULT;
      endcase
   end
endmodule

// File: rtl/privseg_direct.sv
module privseg_direct
   import privseg_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] va_i,
   input  win_t              win_i,
   output logic [ADDR_W-1:0] pa_o
);
   localparam logic [ADDR_W-1:0] BASE_DIR0 = {3'b100, {(ADDR_W-3){1'b0}}};
   localparam logic [ADDR_W-1:0] BASE_DIR1 = {3'b101, {(ADDR_W-3){1'b0}}};

   logic [ADDR_W-1:0] base;

   always_comb begin
      unique case (win_i)
         WIN_DIR0: base = BASE_DIR0;
         WIN_DIR1: base = BASE_DIR1;
         default:  base = '0;
      endcase
      pa_o = va_i - base;
   end
endmodule

// File: rtl/privseg_decoder.sv
module privseg_decoder
   import privseg_pkg::*;
#(
   parameter int unsigned ADDR_W          = 32,
   parameter bit          ERL_OVERRIDE_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] va_i,
   input  logic [1:0]        mode_i,
   input  logic              erl_i,
   input  logic [ADDR_W-1:0] tlb_pa_i,
   input  logic              tlb_rd_i,
   input  logic              tlb_wr_i,
   input  logic [RES_W-1:0]  tlb_res_i,
   output logic              tlb_req_o,
   output logic [ADDR_W-1:0] pa_o,
   output logic              rd_ok_o,
   output logic              wr_ok_o,
   output logic [RES_W-1:0]  result_o
);
   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("privseg_decoder: ADDR_W must be at least 8");
      end
   endgenerate

   win_t              win;
   route_t            route;
   logic [ADDR_W-1:0] direct_pa;

   privseg_classify #(.ADDR_W(ADDR_W)) u_classify (
      .va_i  (va_i),
      .win_o (win)
   );

   privseg_priv #(.ERL_OVERRIDE_EN(ERL_OVERRIDE_EN)) u_priv (
      .win_i   (win),
      .mode_i  (mode_i),
      .erl_i   (erl_i),
      .route_o (route)
   );

   privseg_direct #(.ADDR_W(ADDR_W)) u_direct (
      .va_i  (va_i),
      .win_i (win),
      .pa_o  (direct_pa)
   );

   always_comb begin
      tlb_req_o = 1'b0;
      pa_o      = '0;
      rd_ok_o   = 1'b0;
      wr_ok_o   = 1'b0;
      result_o  = RES_BADADR;
      unique case (route)
         ROUTE_DIRECT: begin
            pa_o     = direct_pa;
            rd_ok_o  = 1'b1;
            wr_ok_o  = 1'b1;
            result_o = RES_OK;
         end
         ROUTE_TLB: begin
            tlb_req_o = 1'b1;
            pa_o      = tlb_pa_i;
            rd_ok_o   = tlb_rd_i;
            wr_ok_o   = tlb_wr_i;
            result_o  = tlb_res_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/privseg_decoder_chk.sv
module privseg_decoder_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic [ADDR_W-1:0] va_i,
   input logic [1:0]        mode_i,
   input logic              erl_i,
   input logic [ADDR_W-1:0] tlb_pa_i,
   input logic [2:0]        tlb_res_i,
   input logic              tlb_req_o,
   input logic [ADDR_W-1:0] pa_o,
   input logic              rd_ok_o,
   input logic              wr_ok_o,
   input logic [2:0]        result_o
);
   logic known;
   logic [2:0] top3;
   assign known = !$isunknown({va_i, mode_i, erl_i, tlb_pa_i, tlb_res_i});
   assign top3  = va_i[ADDR_W-1 -: 3];

   always_comb begin
      if (known) begin
         // R7: a fault never requests the TLB and grants nothing
         a_r7_fault_quiet: assert (!(result_o == 3'd1 && !tlb_req_o) || (!rd_ok_o && !wr_ok_o && pa_o == '0))
            else $error("a_r7_fault_quiet");
         // R2: override lowest window is identity
         a_r2_erl_identity: assert (!(erl_i && !top3[2]) || (!tlb_req_o && pa_o == va_i && result_o == 3'd0))
            else $error("a_r2_erl_identity");
         // R9: pass-through of TLB result when requested
         a_r9_passthru: assert (!tlb_req_o || (result_o == tlb_res_i && pa_o == tlb_pa_i))
            else $error("a_r9_passthru");
         // R6: top window never reaches TLB outside kernel mode
         a_r6_top_kernel: assert (!(top3 == 3'b111 && mode_i != 2'b00) || (!tlb_req_o && result_o == 3'd1))
            else $error("a_r6_top_kernel");
         // R3: direct windows clear the top three bits
         a_r3_direct_pa: assert (!(top3[2:1] == 2'b10 && mode_i == 2'b00) || (pa_o[ADDR_W-1 -: 3] == 3'b000 && pa_o[ADDR_W-4:0] == va_i[ADDR_W-4:0]))
            else $error("a_r3_direct_pa");
      end
   end
endmodule

bind privseg_decoder privseg_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .va_i      (va_i),
   .mode_i    (mode_i),
   .erl_i     (erl_i),
   .tlb_pa_i  (tlb_pa_i),
   .tlb_res_i (tlb_res_i),
   .tlb_req_o (tlb_req_o),
   .pa_o      (pa_o),
   .rd_ok_o   (rd_ok_o),
   .wr_ok_o   (wr_ok_o),
   .result_o  (result_o)
);

// File: tb/privseg_decoder_tb_top.sv
module privseg_decoder_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [31:0] va, tpa, pa;
   logic [1:0]  mode;
   logic        erl, trd, twr, req, rd, wr;
   logic [2:0]  tres, res;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   privseg_decoder dut_i (
      .va_i(va), .mode_i(mode), .erl_i(erl),
      .tlb_pa_i(tpa), .tlb_rd_i(trd), .tlb_wr_i(twr), .tlb_res_i(tres),
      .tlb_req_o(req), .pa_o(pa), .rd_ok_o(rd), .wr_ok_o(wr), .result_o(res)
   );

   // expected: {req, pa, rd, wr, res}
   function automatic logic [37:0] model(input logic [31:0] a, input logic [1:0] m,
                                         input logic e, input logic [31:0] tp,
                                         input logic tr, input logic tw, input logic [2:0] ts);
      bit kern = (m == 2'b00);
      bit sup  = (m == 2'b01);
      logic [37:0] tlbv = {1'b1, tp, tr, tw, ts};
      logic [37:0] bad  = {1'b0, 32'h0, 1'b0, 1'b0, 3'd1};
      if (a < 32'h8000_0000)
         return e ? {1'b0, a, 1'b1, 1'b1, 3'd0} : tlbv;
      else if (a < 32'hA000_0000)
         return kern ? {1'b0, a - 32'h8000_0000, 1'b1, 1'b1, 3'd0} : bad;
      else if (a < 32'hC000_0000)
         return kern ? {1'b0, a - 32'hA000_0000, 1'b1, 1'b1, 3'd0} : bad;
      else if (a < 32'hE000_0000)
         return (kern || sup) ? tlbv : bad;
      else
         return kern ? tlbv : bad;
   endfunction

   task automatic apply(input logic [31:0] a, input logic [1:0] m, input logic e,
                        input logic [31:0] tp, input logic tr, input logic tw,
                        input logic [2:0] ts, input string rq);
      logic [37:0] exp, act;
      @(posedge clk);
      va = a; mode = m; erl = e; tpa = tp; trd = tr; twr = tw; tres = ts;
      @(negedge clk);
      exp = model(a, m, e, tp, tr, tw, ts);
      act = {req, pa, rd, wr, res};
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s va=%h mode=%b erl=%b actual=%h expected=%h", rq, a, m, e, act, exp);
      end
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      va = 0; mode = 0; erl = 0; tpa = 0; trd = 0; twr = 0; tres = 0;
      // reset-like idle state: address 0, kernel, TLB stub all zero
      apply(32'h0, 2'b00, 1'b0, 32'h0, 1'b0, 1'b0, 3'd0, "R1 idle");
      // R1 lowest window to TLB in all modes
      for (int m = 0; m < 4; m++)
         apply(32'h7FFF_FFFF, 2'(m), 1'b0, 32'h1234_5678, 1'b1, 1'b0, 3'd0, "R1 low edge");
      // R2 override, including user mode and boundaries
      apply(32'h0000_0000, 2'b10, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 3'd5, "R2 erl low");
      apply(32'h7FFF_FFFF, 2'b11, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 3'd5, "R2 erl high");
      apply(32'h8000_0000, 2'b10, 1'b1, 32'hDEAD_BEEF, 1'b1, 1'b1, 3'd0, "R7 erl other window");
      // R3 / R4 boundaries
      apply(32'h8000_0000, 2'b00, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd6, "R3 start");
      apply(32'h9FFF_FFFF, 2'b00, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd6, "R3 end");
      apply(32'hA000_0000, 2'b00, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd6, "R4 start");
      apply(32'hBFFF_FFFF, 2'b00, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd6, "R4 end");
      apply(32'h9000_0000, 2'b01, 1'b0, 32'h1, 1'b1, 1'b1, 3'd0, "R7 super direct");
      // R5 / R6
      apply(32'hC000_0000, 2'b01, 1'b0, 32'h0AAA_0000, 1'b1, 1'b1, 3'd4, "R5 super");
      apply(32'hDFFF_FFFF, 2'b10, 1'b0, 32'h0AAA_0000, 1'b1, 1'b1, 3'd0, "R7 user sup win");
      apply(32'hE000_0000, 2'b00, 1'b0, 32'h0BBB_0000, 1'b0, 1'b1, 3'd7, "R6 kernel");
      apply(32'hFFFF_FFFF, 2'b01, 1'b0, 32'h0BBB_0000, 1'b1, 1'b1, 3'd0, "R6 super fault");
      // R8 mode 11 equals user
      apply(32'hC123_4567, 2'b11, 1'b0, 32'h5, 1'b1, 1'b1, 3'd0, "R8 mode11 sup win");
      apply(32'hA000_0010, 2'b11, 1'b0, 32'h5, 1'b1, 1'b1, 3'd0, "R8 mode11 direct win");
      // R9 all result codes passed
      for (int c = 0; c < 8; c++)
         apply(32'h1000_0000, 2'b10, 1'b0, 32'h4000_0000 + c, 1'(c), 1'(c >> 1), 3'(c), "R9 code pass");
      // random
      for (int i = 0; i < 3000; i++)
         apply($urandom, 2'($urandom), 1'($urandom), $urandom, 1'($urandom), 1'($urandom),
               3'($urandom), "R9 random");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule